// File: doc/BRIEF.md
# Two-Wire Serial Controller Register Front End

This block holds the host-visible registers of a two-wire serial bus controller. A host bus reads and writes three byte-wide registers: a control register, a status register and a data register. The block turns the stored control bits into the enable, stop-request, slave-recover and abort signals that drive a separate bus engine. It raises an interrupt request whenever a transfer step has completed and interrupts are allowed.

The bus engine reports back through single-cycle strobes. One marks the completion of a transfer step. One marks that a requested STOP has been carried out. One loads a new 5-bit status code. One loads a received byte into the data register. A host write to the data register while a transfer is still pending is refused, and a sticky collision flag records it. The 2-bit prescaler select is stored in the status register and exported to the bit-rate divider, which scales its period by 1, 4, 16 or 64.

Register select (`host_sel`): 0 picks control, 1 picks status, 2 picks data, and 3 reads as zero. Host reads are combinational on `host_sel`. Writes take effect at the next rising clock edge.

Top module: `serial2w_regs`

## Requirements
- R1: After reset the control register reads 0x00, the status register reads 0xF8 and the data register reads 0xFF. All outputs are low except `tx_byte` (0xFF).
- R2: In master mode (`eng_master`=1), a control write with bit 4 set raises `stop_req` from the next cycle. Bit 4 and `stop_req` stay high until an `eng_stop_done` strobe, and are low in the cycle after it. Writing bit 4 as 0 does not clear a pending request.
- R3: In slave mode, a control write with bit 4 set leaves `stop_req` and control bit 4 low. It pulses `slave_reset` high for exactly one cycle.
- R4: A data-register write while the completion flag (control bit 7) is low sets the collision flag (control bit 3). It leaves the stored byte unchanged.
- R5: A data-register write while the completion flag is high stores the byte and clears the collision flag.
- R6: Control bit 2 drives `if_enable`. A control write that clears bit 2 while it is set pulses `abort` for one cycle and drops any pending stop request.
- R7: `irq_req` is high exactly while control bit 0, `glob_irq_en` and the completion flag are all high.
- R8: Status bits 7..3 hold the last code loaded by `eng_code_vld`, and bit 2 reads 0. Bits 1..0 are a host-writable prescaler select driven on `prescale_sel`. Host writes do not change bits 7..2.
- R9: Control bits 6, 5 and 1 always read as zero, whatever is written to them.
- R10: An `eng_rx_vld` strobe loads `eng_rx_byte` into the data register, and it wins over a host data write in the same cycle.
- R11: `eng_done` sets the completion flag. A control write with bit 7 set clears it. If both happen in the same cycle, the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 2 | Register select |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data of selected register |
| glob_irq_en | input | 1 | Global interrupt enable |
| eng_master | input | 1 | Engine is in master mode |
| eng_done | input | 1 | Transfer step complete strobe |
| eng_stop_done | input | 1 | STOP executed strobe |
| eng_code_vld | input | 1 | Status code load strobe |
| eng_code | input | 5 | Status code from engine |
| eng_rx_vld | input | 1 | Received byte load strobe |
| eng_rx_byte | input | 8 | Received byte |
| if_enable | output | 1 | Interface enable |
| stop_req | output | 1 | STOP request to engine |
| slave_reset | output | 1 | One-cycle return-to-unaddressed-slave pulse |
| abort | output | 1 | One-cycle transfer abort pulse |
| irq_req | output | 1 | Interrupt request |
| prescale_sel | output | 2 | Prescaler select to the divider |
| tx_byte | output | 8 | Data register contents |

## Verification
The assertions assume the engine strobes are single-cycle pulses and that `eng_master` stays steady around a stop-bit write. The stop-clear property only counts cycles in which no new host stop write coincides with `eng_stop_done`. The stimulus changes mode only between operations and holds every strobe for one cycle. It also includes the deliberate same-cycle collisions (done with clear, receive with host write) whose outcome the requirements fix.

// File: rtl/s2w_pkg.sv
package s2w_pkg;
    localparam int BYTE_W = 8;
    localparam int CODE_W = 5;
    localparam int PS_W   = 2;
    localparam int SEL_W  = 2;

    localparam logic [SEL_W-1:0] SEL_CTRL = 2'd0;
    localparam logic [SEL_W-1:0] SEL_STAT = 2'd1;
    localparam logic [SEL_W-1:0] SEL_DATA = 2'd2;

    localparam int B_DONE = 7;
    localparam int B_STOP = 4;
    localparam int B_COLL = 3;
    localparam int B_EN   = 2;
    localparam int B_IE   = 0;

    localparam logic [CODE_W-1:0] CODE_IDLE = '1;
    localparam logic [BYTE_W-1:0] DATA_RST  = '1;

    typedef struct packed {
        logic clr_done;
        logic stop;
        logic en;
        logic ie;
    } ctrl_wr_t;

    typedef struct packed {
        logic done;
        logic stop;
        logic en;
        logic ie;
        logic abort;
        logic slv_rst;
    } ctrl_st_t;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              coll;
    } data_st_t;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [PS_W-1:0]   ps;
    } stat_st_t;
endpackage

// File: rtl/s2w_ctrl_bits.sv
module s2w_ctrl_bits
    import s2w_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr,
    input  ctrl_wr_t wbits,
    input  logic     eng_master,
    input  logic     eng_done,
    input  logic     eng_stop_done,
    output ctrl_st_t st
);
    ctrl_st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.abort   = 1'b0;
        st_d.slv_rst = 1'b0;
        if (eng_done)
            st_d.done = 1'b1;
        else if (wr && wbits.clr_done)
            st_d.done = 1'b0;
        if (eng_stop_done)
            st_d.stop = 1'b0;
        if (wr) begin
            st_d.en = wbits.en;
            st_d.ie = wbits.ie;
            if (st_q.en && !wbits.en)
                st_d.abort = 1'b1;
            if (wbits.stop) begin
                if (eng_master)
                    st_d.stop = 1'b1;
                else
                    st_d.slv_rst = 1'b1;
            end
        end
        if (!st_d.en)
            st_d.stop = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign st = st_q;

    assert_stop_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.stop && eng_stop_done && !(wr && wbits.stop)) |=> !st_q.stop);

    assert_slave_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.slv_rst |=> !st_q.slv_rst);

    assert_abort_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.en) |-> (st_q.abort && !st_q.stop));

    assert_done_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> st_q.done);
endmodule

// File: rtl/s2w_data_reg.sv
module s2w_data_reg
    import s2w_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              done,
    input  logic              rx_vld,
    input  logic [BYTE_W-1:0] rx_byte,
    output data_st_t          st
);
    data_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            if (done) begin
                st_d.data = wdata;
                st_d.coll = 1'b0;
            end else begin
                st_d.coll = 1'b1;
            end
        end
        if (rx_vld)
            st_d.data = rx_byte;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.data <= DATA_RST;
            st_q.coll <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign st = st_q;

    assert_collision_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !done && !rx_vld) |=> (st_q.coll && $stable(st_q.data)));

    assert_write_ok_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && done && !rx_vld) |=> (!st_q.coll && st_q.data == $past(wdata)));

    assert_rx_priority_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_vld |=> st_q.data == $past(rx_byte));
endmodule

// File: rtl/s2w_stat_reg.sv
module s2w_stat_reg
    import s2w_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [PS_W-1:0]   wps,
    input  logic              code_vld,
    input  logic [CODE_W-1:0] code,
    output stat_st_t          st
);
    stat_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr)
            st_d.ps = wps;
        if (code_vld)
            st_d.code = code;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.code <= CODE_IDLE;
            st_q.ps   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign st = st_q;

    assert_code_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !code_vld |=> $stable(st_q.code));

    assert_prescale_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> st_q.ps == $past(wps));
endmodule

// File: rtl/serial2w_regs.sv
module serial2w_regs
    import s2w_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  host_sel,
    input  logic        host_wr,
    input  logic [7:0]  host_wdata,
    output logic [7:0]  host_rdata,
    input  logic        glob_irq_en,
    input  logic        eng_master,
    input  logic        eng_done,
    input  logic        eng_stop_done,
    input  logic        eng_code_vld,
    input  logic [4:0]  eng_code,
    input  logic        eng_rx_vld,
    input  logic [7:0]  eng_rx_byte,
    output logic        if_enable,
    output logic        stop_req,
    output logic        slave_reset,
    output logic        abort,
    output logic        irq_req,
    output logic [1:0]  prescale_sel,
    output logic [7:0]  tx_byte
);
    logic     wr_ctrl, wr_stat, wr_data;
    ctrl_wr_t cw;
    ctrl_st_t cst;
    data_st_t dst;
    stat_st_t sst;
    logic [BYTE_W-1:0] ctrl_view, stat_view;

    assign wr_ctrl = host_wr && (host_sel == SEL_CTRL);
    assign wr_stat = host_wr && (host_sel == SEL_STAT);
    assign wr_data = host_wr && (host_sel == SEL_DATA);

    assign cw.clr_done = host_wdata[B_DONE];
    assign cw.stop     = host_wdata[B_STOP];
    assign cw.en       = host_wdata[B_EN];
    assign cw.ie       = host_wdata[B_IE];

    s2w_ctrl_bits i_ctrl (
        .clk(clk), .rst_n(rst_n), .wr(wr_ctrl), .wbits(cw),
        .eng_master(eng_master), .eng_done(eng_done),
        .eng_stop_done(eng_stop_done), .st(cst)
    );

    s2w_data_reg i_data (
        .clk(clk), .rst_n(rst_n), .wr(wr_data), .wdata(host_wdata),
        .done(cst.done), .rx_vld(eng_rx_vld), .rx_byte(eng_rx_byte), .st(dst)
    );

    s2w_stat_reg i_stat (
        .clk(clk), .rst_n(rst_n), .wr(wr_stat), .wps(host_wdata[PS_W-1:0]),
        .code_vld(eng_code_vld), .code(eng_code), .st(sst)
    );

    always_comb begin
        ctrl_view         = '0;
        ctrl_view[B_DONE] = cst.done;
        ctrl_view[B_STOP] = cst.stop;
        ctrl_view[B_COLL] = dst.coll;
        ctrl_view[B_EN]   = cst.en;
        ctrl_view[B_IE]   = cst.ie;
        stat_view         = {sst.code, 1'b0, sst.ps};
        case (host_sel)
            SEL_CTRL: host_rdata = ctrl_view;
            SEL_STAT: host_rdata = stat_view;
            SEL_DATA: host_rdata = dst.data;
            default:  host_rdata = '0;
        endcase
    end

    assign if_enable    = cst.en;
    assign stop_req     = cst.stop;
    assign slave_reset  = cst.slv_rst;
    assign abort        = cst.abort;
    assign irq_req      = cst.ie && glob_irq_en && cst.done;
    assign prescale_sel = sst.ps;
    assign tx_byte      = dst.data;

    assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_sel == SEL_CTRL) |-> (host_rdata[6:5] == 2'b00 && host_rdata[1] == 1'b0));

    assert_irq_needs_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (glob_irq_en && cst.done));
endmodule

// File: tb/test_serial2w_regs.sv
module test_serial2w_regs;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] host_sel;
    logic       host_wr;
    logic [7:0] host_wdata;
    logic [7:0] host_rdata;
    logic       glob_irq_en, eng_master, eng_done, eng_stop_done;
    logic       eng_code_vld, eng_rx_vld;
    logic [4:0] eng_code;
    logic [7:0] eng_rx_byte;
    logic       if_enable, stop_req, slave_reset, abort, irq_req;
    logic [1:0] prescale_sel;
    logic [7:0] tx_byte;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // reference state
    bit       m_done, m_stop, m_en, m_ie, m_coll, m_abort, m_sr;
    bit [7:0] m_data;
    bit [4:0] m_code;
    bit [1:0] m_ps;

    always #2.5 clk = ~clk;

    serial2w_regs i_serial2w_regs (.*);

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic bit [7:0] m_read(bit [1:0] s);
        case (s)
            2'd0: return {m_done, 2'b00, m_stop, m_coll, m_en, 1'b0, m_ie};
            2'd1: return {m_code, 1'b0, m_ps};
            2'd2: return m_data;
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_reset();
        m_done = 0; m_stop = 0; m_en = 0; m_ie = 0; m_coll = 0;
        m_abort = 0; m_sr = 0; m_data = 8'hFF; m_code = 5'h1F; m_ps = 0;
    endtask

    task automatic model_clock();
        bit n_done, n_stop, n_en, n_ie, n_coll, n_abort, n_sr;
        bit [7:0] n_data;
        bit wc, ws, wd;
        if (!rst_n) begin
            model_reset();
            return;
        end
        wc = host_wr && host_sel == 0;
        ws = host_wr && host_sel == 1;
        wd = host_wr && host_sel == 2;
        n_done = eng_done ? 1 : (wc && host_wdata[7]) ? 0 : m_done;
        n_en = wc ? host_wdata[2] : m_en;
        n_ie = wc ? host_wdata[0] : m_ie;
        n_abort = wc && m_en && !host_wdata[2];
        n_sr = wc && host_wdata[4] && !eng_master;
        n_stop = m_stop;
        if (eng_stop_done) n_stop = 0;
        if (wc && host_wdata[4] && eng_master) n_stop = 1;
        if (!n_en) n_stop = 0;
        n_coll = m_coll;
        n_data = m_data;
        if (wd) begin
            if (m_done) begin n_data = host_wdata; n_coll = 0; end
            else n_coll = 1;
        end
        if (eng_rx_vld) n_data = eng_rx_byte;
        if (ws) m_ps = host_wdata[1:0];
        if (eng_code_vld) m_code = eng_code;
        m_done = n_done; m_stop = n_stop; m_en = n_en; m_ie = n_ie;
        m_coll = n_coll; m_abort = n_abort; m_sr = n_sr; m_data = n_data;
    endtask

    // compare current outputs, then advance one clock
    task automatic step(string tag);
        #1;
        chk(tag, "rdata", host_rdata, m_read(host_sel));
        chk(tag, "irq", irq_req, m_ie && glob_irq_en && m_done);
        chk(tag, "enable", if_enable, m_en);
        chk(tag, "stop_req", stop_req, m_stop);
        chk(tag, "slave_reset", slave_reset, m_sr);
        chk(tag, "abort", abort, m_abort);
        chk(tag, "prescale", prescale_sel, m_ps);
        chk(tag, "tx_byte", tx_byte, m_data);
        @(posedge clk);
        model_clock();
        @(negedge clk);
    endtask

    task automatic idle();
        host_wr = 0; eng_done = 0; eng_stop_done = 0;
        eng_code_vld = 0; eng_rx_vld = 0;
    endtask

    task automatic hwrite(bit [1:0] s, bit [7:0] v, string tag);
        host_sel = s; host_wr = 1; host_wdata = v;
        step(tag);
        host_wr = 0;
    endtask

    task automatic look(bit [1:0] s, string tag);
        host_sel = s;
        step(tag);
    endtask

    initial begin
        #100000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        model_reset();
        rst_n = 0; host_sel = 0; host_wdata = 0; glob_irq_en = 0;
        eng_master = 1; eng_code = 0; eng_rx_byte = 0;
        idle();
        @(negedge clk);
        look(0, "R1"); look(1, "R1"); look(2, "R1"); look(3, "R1");
        rst_n = 1;
        look(0, "R1"); look(1, "R1"); look(2, "R1");

        // R9: reserved bits read zero; enable and ie set
        hwrite(0, 8'h67, "R9");
        look(0, "R9");
        look(0, "R6");

        // R11 / R7: completion flag and interrupt gating
        eng_done = 1; look(0, "R11"); eng_done = 0;
        look(0, "R7");
        glob_irq_en = 1; look(0, "R7");
        glob_irq_en = 0; look(0, "R7");
        glob_irq_en = 1;
        hwrite(0, 8'h85, "R11");           // clear done, keep en/ie
        look(0, "R11");
        eng_done = 1; hwrite(0, 8'h85, "R11"); eng_done = 0;  // set wins
        look(0, "R11"); look(0, "R7");

        // R5: write with flag high
        hwrite(2, 8'hA5, "R5");
        look(2, "R5"); look(0, "R5");
        hwrite(0, 8'h85, "R4");             // clear flag
        // R4: collision
        hwrite(2, 8'h3C, "R4");
        look(2, "R4"); look(0, "R4");
        hwrite(2, 8'h11, "R4");
        look(0, "R4");
        eng_done = 1; look(0, "R5"); eng_done = 0;
        hwrite(2, 8'h5A, "R5");
        look(0, "R5"); look(2, "R5");

        // R10: receive strobe vs host write
        eng_rx_vld = 1; eng_rx_byte = 8'hC3;
        hwrite(2, 8'h77, "R10");
        eng_rx_vld = 0;
        look(2, "R10");
        eng_rx_vld = 1; eng_rx_byte = 8'h0F; look(2, "R10"); eng_rx_vld = 0;
        look(2, "R10");

        // R2: stop in master mode
        eng_master = 1;
        hwrite(0, 8'h14, "R2");
        look(0, "R2"); look(0, "R2");
        hwrite(0, 8'h04, "R2");            // writing 0 keeps it
        look(0, "R2");
        eng_stop_done = 1; look(0, "R2"); eng_stop_done = 0;
        look(0, "R2");

        // R3: stop in slave mode
        eng_master = 0;
        hwrite(0, 8'h14, "R3");
        look(0, "R3"); look(0, "R3");
        eng_master = 1;

        // R6: disable aborts and drops pending stop
        hwrite(0, 8'h14, "R6");
        look(0, "R6");
        hwrite(0, 8'h10, "R6");
        look(0, "R6"); look(0, "R6");
        hwrite(0, 8'h00, "R6");            // already off: no abort
        look(0, "R6");

        // R8: status register
        hwrite(1, 8'hFF, "R8");
        look(1, "R8");
        hwrite(1, 8'h02, "R8");
        look(1, "R8");
        eng_code_vld = 1; eng_code = 5'h0A; look(1, "R8"); eng_code_vld = 0;
        look(1, "R8");
        hwrite(1, 8'h01, "R8");
        look(1, "R8");
        look(3, "R8");

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule